// File: doc/BRIEF.md
# PHY Tuning Parameter Loader

This block owns three PHY tuning registers: two PHY parameter words and one twisted-pair parameter word. A configuration input decides who may write them. With automatic loading selected, every time the link comes up while running at 100 Mbps the block reads the two PHY parameter words from a small serial EEPROM over a three-wire Microwire link. In that mode it refuses all software writes to the three registers.

With automatic loading off, the block starts no EEPROM reads. Software may then write any of the three registers, but only while both bits of the EEPROM command-mode field are set. A link-up edge that arrives while a load is running is remembered, and it causes exactly one more load once the current one finishes.

Top module: `phy_parm_loader`

## Requirements
- R1: After synchronous reset the outputs hold their reset values: `phy1_parm`, `phy2_parm` and `twist_parm` equal the parameters `PHY1_INIT`, `PHY2_INIT` and `TWIST_INIT`; `load_busy`, `ee_cs`, `ee_sk` and `ee_di` are 0.
- R2: While `parm_auto` is 1, a software write strobe changes none of the three registers, for any value of `eem_mode` and `sw_sel`.
- R3: While `parm_auto` is 0 and `eem_mode` is 2'b11, a `sw_we` pulse stores `sw_data` on the next clock edge. The target is chosen by `sw_sel`: 0 selects PHY1, 1 selects PHY2, 2 selects twister, and 3 selects no register.
- R4: While `parm_auto` is 0 and `eem_mode` is not 2'b11, a software write strobe changes no register.
- R5: With `parm_auto` at 1, a rising edge of `link_ok_in` while `speed_100` is 1 starts one load. The load reads EEPROM word `PHY1_ADDR` into `phy1_parm` and then word `PHY2_ADDR` into `phy2_parm`, and leaves `twist_parm` unchanged.
- R6: A link-up with `speed_100` at 0, or with `parm_auto` at 0, starts no EEPROM access.
- R7: Each EEPROM read is one frame with `ee_cs` high. The frame has 9 command bits on `ee_di`: start bit 1, opcode 1 then 0, and the 6-bit word address MSB first. It then takes 16 data bits from `ee_do`, MSB first. Each bit takes one `ee_sk` period of 2*`CLK_DIV` clocks, and the EEPROM sees 25 rising `ee_sk` edges per frame.
- R8: Between two frames `ee_cs` stays low for at least 2*`CLK_DIV` clocks, which is one serial clock period. `ee_sk` is low whenever `ee_cs` is low.
- R9: `load_busy` rises after the link-up trigger and falls on the same clock edge that writes `phy2_parm`. `ee_cs` is never high while `load_busy` is low.
- R10: A qualifying link-up edge during a running load is latched, and it causes exactly one further two-word load after the current one.
- R11: `link_ok_in` passes through a two-stage synchronizer. A level held high causes only one load; each new rising edge causes a reload that picks up the current EEPROM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ok_in | input | 1 | Asynchronous link-good level from the PHY |
| speed_100 | input | 1 | High when the link runs at 100 Mbps |
| parm_auto | input | 1 | 1: EEPROM owns the registers; 0: software owns them |
| eem_mode | input | 2 | EEPROM command-mode bits; 2'b11 unlocks software writes |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 0 PHY1, 1 PHY2, 2 twister, 3 none |
| sw_data | input | DATA_W | Software write data |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| phy1_parm | output | DATA_W | PHY parameter word 1 |
| phy2_parm | output | DATA_W | PHY parameter word 2 |
| twist_parm | output | DATA_W | Twister parameter word |
| load_busy | output | 1 | High while a load sequence runs |

## Verification
The write gate is swept over every combination of ownership bit, mode field and target select. Each write uses fresh data, so a write that lands on the wrong register is distinguished from one that was correctly refused. Link-up events are tried at 10 Mbps, at 100 Mbps with software ownership, and at 100 Mbps with EEPROM ownership, which separates speed qualification from ownership gating. A behavioural EEPROM returns address-dependent words, so swapped addresses or bit order show up as wrong values. A second edge during a load, and an EEPROM content change before a relink, tell latching apart from dropping and a fresh load apart from a stale one.

// File: rtl/parm_ld_pkg.sv
package parm_ld_pkg;
  typedef enum logic [1:0] {
    SEL_PHY1  = 2'd0,
    SEL_PHY2  = 2'd1,
    SEL_TWIST = 2'd2,
    SEL_NONE  = 2'd3
  } parm_sel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WORD1 = 2'd1,
    SEQ_WORD2 = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    MW_IDLE  = 2'd0,
    MW_SHIFT = 2'd1,
    MW_GAP   = 2'd2
  } mw_state_e;

  localparam int  NUM_REGS = 3;
  localparam logic       MW_START = 1'b1;
  localparam logic [1:0] MW_OP_RD = 2'b10;
  localparam logic [1:0] EEM_UNLOCK = 2'b11;
endpackage

// File: rtl/link_edge_det.sv
module link_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic link_ok_in,
  input  logic speed_100,
  input  logic enable,
  input  logic ack,
  output logic req
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       pend_q;
  logic       rise;

  assign rise = sync_q[1] & ~prev_q & speed_100 & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], link_ok_in};
      prev_q <= sync_q[1];
      pend_q <= (pend_q & ~ack) | rise;
    end
  end

  assign req = pend_q;

  AST_REQ_ONLY_100M: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(speed_100) && $past(enable)); // R6
endmodule

// File: rtl/mw_reader.sv
module mw_reader import parm_ld_pkg::*; #(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_N = CMD_W + DATA_W;
  localparam int DIV_W   = $clog2(CLK_DIV + 1);
  localparam int BIT_W   = $clog2(FRAME_N + 1);
  localparam int GAP_MIN = 2 * CLK_DIV;
  localparam int GCNT_W  = $clog2(GAP_MIN + 1);

  mw_state_e         st_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] shf_q;
  logic              cs_q, sk_q, di_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              tick;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= MW_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      cmd_q   <= '0;
      shf_q   <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      div_q  <= tick ? '0 : div_q + 1'b1;
      case (st_q)
        MW_IDLE: begin
          div_q <= '0;
          if (start) begin
            st_q  <= MW_SHIFT;
            cs_q  <= 1'b1;
            sk_q  <= 1'b0;
            bit_q <= '0;
            di_q  <= MW_START;
            cmd_q <= {MW_OP_RD, addr, 1'b0};
          end
        end
        MW_SHIFT: begin
          if (tick) begin
            if (!sk_q) begin
              sk_q <= 1'b1;
            end else begin
              sk_q <= 1'b0;
              if (bit_q >= BIT_W'(CMD_W)) shf_q <= {shf_q[DATA_W-2:0], ee_do};
              if (bit_q == BIT_W'(FRAME_N - 1)) begin
                rdata_q <= {shf_q[DATA_W-2:0], ee_do};
                st_q    <= MW_GAP;
                cs_q    <= 1'b0;
                di_q    <= 1'b0;
                bit_q   <= '0;
              end else begin
                bit_q <= bit_q + 1'b1;
                di_q  <= cmd_q[CMD_W-1];
                cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
              end
            end
          end
        end
        default: begin
          if (tick) begin
            if (bit_q == BIT_W'(1)) begin
              st_q   <= MW_IDLE;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = di_q;
  assign done  = done_q;
  assign rdata = rdata_q;

  // checker counter: clocks with chip select low
  logic [GCNT_W-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= GCNT_W'(GAP_MIN);
    else if (cs_q)  low_cnt <= '0;
    else if (low_cnt < GCNT_W'(GAP_MIN)) low_cnt <= low_cnt + 1'b1;
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> $past(low_cnt) >= GCNT_W'(GAP_MIN)); // R8
  AST_SK_PARKED: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk); // R8
endmodule

// File: rtl/parm_regs.sv
module parm_regs import parm_ld_pkg::*; #(
  parameter int          DATA_W     = 16,
  parameter logic [15:0] PHY1_INIT  = 16'h0000,
  parameter logic [15:0] PHY2_INIT  = 16'h0000,
  parameter logic [15:0] TWIST_INIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              parm_auto,
  input  logic [1:0]        eem_mode,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              ld_we,
  input  logic              ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] phy1_parm,
  output logic [DATA_W-1:0] phy2_parm,
  output logic [DATA_W-1:0] twist_parm
);
  localparam logic [DATA_W-1:0] INIT_V [NUM_REGS] =
    '{DATA_W'(PHY1_INIT), DATA_W'(PHY2_INIT), DATA_W'(TWIST_INIT)};

  logic              sw_ok;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  assign sw_ok = sw_we & ~parm_auto & (eem_mode == EEM_UNLOCK);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic ld_hit, sw_hit;
    if (g < 2) begin : g_ld
      assign ld_hit = ld_we & (ld_sel == g[0]);
    end else begin : g_nold
      assign ld_hit = 1'b0;
    end
    assign sw_hit = sw_ok & (sw_sel == 2'(g));
    always_ff @(posedge clk) begin
      if (rst)         regs_q[g] <= INIT_V[g];
      else if (ld_hit) regs_q[g] <= ld_data;
      else if (sw_hit) regs_q[g] <= sw_data;
    end
  end

  assign phy1_parm  = regs_q[0];
  assign phy2_parm  = regs_q[1];
  assign twist_parm = regs_q[2];

  AST_SW_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (parm_auto && !ld_we) |=> $stable(phy1_parm) && $stable(phy2_parm) && $stable(twist_parm)); // R2
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!parm_auto && eem_mode == EEM_UNLOCK && sw_we && sw_sel == SEL_TWIST) |=> twist_parm == $past(sw_data)); // R3
  AST_EEM_GATE: assert property (@(posedge clk) disable iff (rst)
    (!parm_auto && eem_mode != EEM_UNLOCK && !ld_we) |=> $stable(twist_parm) && $stable(phy1_parm)); // R4
endmodule

// File: rtl/phy_parm_loader.sv
module phy_parm_loader import parm_ld_pkg::*; #(
  parameter int          CLK_DIV    = 4,
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 16,
  parameter logic [5:0]  PHY1_ADDR  = 6'h07,
  parameter logic [5:0]  PHY2_ADDR  = 6'h08,
  parameter logic [15:0] PHY1_INIT  = 16'h1111,
  parameter logic [15:0] PHY2_INIT  = 16'h2222,
  parameter logic [15:0] TWIST_INIT = 16'h3333
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_ok_in,
  input  logic              speed_100,
  input  logic              parm_auto,
  input  logic [1:0]        eem_mode,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic [DATA_W-1:0] phy1_parm,
  output logic [DATA_W-1:0] phy2_parm,
  output logic [DATA_W-1:0] twist_parm,
  output logic              load_busy
);
  seq_state_e        st_q;
  logic              req, ack, rd_start, rd_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              ld_we, ld_sel;

  link_edge_det u_edge (
    .clk(clk), .rst(rst), .link_ok_in(link_ok_in), .speed_100(speed_100),
    .enable(parm_auto), .ack(ack), .req(req)
  );

  always_comb begin
    ack      = 1'b0;
    rd_start = 1'b0;
    rd_addr  = ADDR_W'(PHY1_ADDR);
    ld_we    = 1'b0;
    ld_sel   = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        ack      = req;
        rd_start = req;
      end
      SEQ_WORD1: begin
        ld_we    = rd_done;
        rd_start = rd_done;
        rd_addr  = ADDR_W'(PHY2_ADDR);
      end
      SEQ_WORD2: begin
        ld_we  = rd_done;
        ld_sel = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_IDLE;
    else begin
      case (st_q)
        SEQ_IDLE:  if (req)     st_q <= SEQ_WORD1;
        SEQ_WORD1: if (rd_done) st_q <= SEQ_WORD2;
        SEQ_WORD2: if (rd_done) st_q <= SEQ_IDLE;
        default:                st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign load_busy = (st_q != SEQ_IDLE);

  mw_reader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mw (
    .clk(clk), .rst(rst), .start(rd_start), .addr(rd_addr), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .done(rd_done), .rdata(rd_data)
  );

  parm_regs #(.DATA_W(DATA_W), .PHY1_INIT(PHY1_INIT), .PHY2_INIT(PHY2_INIT),
              .TWIST_INIT(TWIST_INIT)) u_regs (
    .clk(clk), .rst(rst), .parm_auto(parm_auto), .eem_mode(eem_mode),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(sw_data),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_data(rd_data),
    .phy1_parm(phy1_parm), .phy2_parm(phy2_parm), .twist_parm(twist_parm)
  );

  AST_CS_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
    ee_cs |-> load_busy); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_WORD2 && rd_done) |=> !load_busy && phy2_parm == $past(rd_data)); // R9
  AST_TWIST_KEPT: assert property (@(posedge clk) disable iff (rst)
    (load_busy && !sw_we) |=> $stable(twist_parm)); // R5
endmodule

// File: tb/tb_phy_parm_loader.sv
module tb_phy_parm_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam logic [5:0]  A1 = 6'h0B;
  localparam logic [5:0]  A2 = 6'h2C;
  localparam logic [15:0] I1 = 16'hA1A1, I2 = 16'hB2B2, I3 = 16'hC3C3;

  logic clk = 1'b0, rst = 1'b1;
  logic link_ok_in = 0, speed_100 = 0, parm_auto = 0, sw_we = 0, ee_do = 0;
  logic [1:0] eem_mode = 0, sw_sel = 0;
  logic [15:0] sw_data = 0;
  logic ee_cs, ee_sk, ee_di, load_busy;
  logic [15:0] phy1_parm, phy2_parm, twist_parm;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_r [3];
  logic [15:0] ee_mem [64];
  int frames = 0;
  logic [5:0] last_addr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_parm_loader #(.CLK_DIV(DIV), .PHY1_ADDR(A1), .PHY2_ADDR(A2),
    .PHY1_INIT(I1), .PHY2_INIT(I2), .TWIST_INIT(I3)) dut (
    .clk(clk), .rst(rst), .link_ok_in(link_ok_in), .speed_100(speed_100),
    .parm_auto(parm_auto), .eem_mode(eem_mode), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_data(sw_data), .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .phy1_parm(phy1_parm), .phy2_parm(phy2_parm), .twist_parm(twist_parm),
    .load_busy(load_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural serial EEPROM
  int bitc = 0;
  logic [8:0] cmd = 0;
  bit per_ok = 1;
  time t_sk = 0, t_fall = 0;
  always @(posedge ee_cs) begin
    bitc = 0; cmd = 0; per_ok = 1;
    if (frames > 0 && ($time - t_fall) < 2*DIV*CLK_PERIOD) chk("R8 cs gap", 0, 1);
    else if (frames > 0) chk("R8 cs gap", 1, 1);
  end
  always @(posedge ee_sk) if (ee_cs) begin
    if (bitc > 0 && ($time - t_sk) != 2*DIV*CLK_PERIOD) per_ok = 0;
    t_sk = $time;
    if (bitc < 9) cmd = {cmd[7:0], ee_di};
    else ee_do <= ee_mem[cmd[5:0]][15-(bitc-9)];
    bitc++;
  end
  always @(negedge ee_cs) if (!rst) begin
    t_fall = $time;
    chk("R7 frame cmd/len/period", {cmd[8:6], 8'(bitc), 1'(per_ok)}, {3'b110, 8'd25, 1'b1});
    last_addr[frames % 8] = cmd[5:0];
    frames++;
  end

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 64; i++) ee_mem[i] = 16'((i * 16'h1357) ^ (seed * 16'h0F1D) ^ 16'h5AC3);
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " phy1"}, phy1_parm, exp_r[0]);
    chk({tag, " phy2"}, phy2_parm, exp_r[1]);
    chk({tag, " twist"}, twist_parm, exp_r[2]);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (load_busy && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk("R9 busy timeout", 1, 0);
  endtask

  task automatic link_up();
    link_ok_in = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fill_mem(1);
    exp_r[0] = I1; exp_r[1] = I2; exp_r[2] = I3;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    chk("R1 busy/cs/sk/di", {load_busy, ee_cs, ee_sk, ee_di}, 4'b0000);

    // R2 R3 R4 full sweep of the write gate
    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++) begin
          parm_auto = a[0]; eem_mode = m[1:0]; sw_sel = s[1:0];
          sw_data = 16'(16'h1000 + a*64 + m*16 + s);
          sw_we = 1;
          @(negedge clk);
          sw_we = 0;
          if (a == 0 && m == 3 && s < 3) exp_r[s] = sw_data;
          if (a == 1) check_regs("R2 locked");
          else if (m == 3) check_regs("R3 unlocked");
          else check_regs("R4 mode gate");
        end

    // R6 link-up at 10 Mbps and with software ownership
    parm_auto = 1; speed_100 = 0; link_up();
    repeat (60) @(negedge clk);
    chk("R6 10M no frame", frames, 0);
    chk("R6 10M no busy", load_busy, 0);
    link_ok_in = 0; repeat (4) @(negedge clk);
    parm_auto = 0; speed_100 = 1; link_up();
    repeat (60) @(negedge clk);
    chk("R6 sw-owned no frame", frames, 0);
    link_ok_in = 0; repeat (4) @(negedge clk);

    // R5 R9 single load
    parm_auto = 1; link_up();
    chk("R9 busy after trigger", load_busy, 1);
    wait_idle();
    exp_r[0] = ee_mem[A1]; exp_r[1] = ee_mem[A2];
    check_regs("R5 load");
    chk("R5 two frames", frames, 2);
    chk("R5 addr order", {last_addr[0], last_addr[1]}, {A1, A2});
    // R11 level held: no reload
    repeat (100) @(negedge clk);
    chk("R11 held level", frames, 2);

    // R11 fresh contents on relink
    fill_mem(7);
    link_ok_in = 0; repeat (4) @(negedge clk);
    link_up();
    wait_idle();
    exp_r[0] = ee_mem[A1]; exp_r[1] = ee_mem[A2];
    check_regs("R11 reload");
    chk("R11 frames", frames, 4);

    // R10 edge during a load is latched, one extra load
    link_ok_in = 0; repeat (4) @(negedge clk);
    link_up();
    while (!ee_cs) @(negedge clk);
    link_ok_in = 0; repeat (4) @(negedge clk);
    link_ok_in = 1; repeat (4) @(negedge clk);
    link_ok_in = 0; repeat (4) @(negedge clk);
    link_ok_in = 1;
    wait_idle();
    @(negedge clk); @(negedge clk);
    wait_idle();
    repeat (200) @(negedge clk);
    chk("R10 one extra load", frames, 8);
    chk("R10 busy clear", load_busy, 0);
    check_regs("R10 regs");

    // R2 software write during EEPROM ownership after loads
    eem_mode = 2'b11; sw_sel = 2'd2; sw_data = 16'hDEAD; sw_we = 1;
    @(negedge clk); sw_we = 0;
    check_regs("R2 after load");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule